// File: doc/BRIEF.md
# Readout Protection Access Gate

This block filters bus requests aimed at the protected memories of a chip: the main flash array, the backup register file and the retained SRAM. It also handles requests to the option-byte store and to unprotected space. For every accepted request it returns one response a cycle later. The response either grants the access or flags a bus error. On an error it pulses the hard-fault line of the core that issued the request.

The decision depends on four things: the current protection level, the boot mode, whether a debugger is attached and whether the secure core is enabled. The gate also turns the incoming boot request into the boot mode that is actually used, falling back to flash boot when the level forbids the request, and keeps a sticky flag once such a fallback has happened. It drives the debug-port enable, which is off at the highest level and always off while reset is asserted.

The gate does not choose the protection level, run erase sequences or hold any memory. Those are supplied and done elsewhere.

Top module: `rdp_access_gate`

## Requirements
- R1: While rst_n is low, req_ready, rsp_valid, rsp_error, fault, dbg_en and boot_fallback are all 0.
- R2: At level 0 (prot_level = 0) every accepted request is granted (rsp_error = 0), whatever the boot mode, debug flag or region.
- R3: At any nonzero level, when dbg_active is 1 or the effective boot mode (boot_sel) is not flash, a request to region 0 (main flash), 1 (backup registers) or 2 (retained SRAM) is refused. Region 3 (option bytes) and regions 4 to 7 (unprotected) are not refused for this reason.
- R4: An accepted request produces rsp_valid = 1 in the following cycle, and only then. rsp_error is 1 in that cycle exactly when the request is refused.
- R5: On a refused request, fault bit i is 1 only in the response cycle, where i is the req_core of the refused request. Every other fault bit stays 0.
- R6: Level codes 2 and 3 both mean the locked level. One cycle after a locked level is presented, dbg_en is 0. One cycle after level 0 or 1 is presented, dbg_en is 1.
- R7: Boot modes are coded 0 = flash, 1 = boot RAM, 2 = loader, 3 = secure install. boot_sel follows boot_req combinationally, except at the locked level, where boot_sel is 0 in two cases: boot_req is 1 or 2, or boot_req is 3 while sboot_lock is 1.
- R8: boot_fallback becomes 1 in the cycle after boot_sel has been forced to 0 by R7, and it stays 1 until reset.
- R9: At the locked level, an option-byte write (region 3, req_write = 1) is refused unless req_core equals the secure core index (1) and sec_core_en is 1. Option-byte reads are not refused for this reason.
- R10: At the locked level with flash boot and dbg_active = 0, requests to regions 0 to 2 are granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_level | input | 2 | Protection level: 0 open, 1 guarded, 2 or 3 locked |
| boot_req | input | 2 | Requested boot mode |
| dbg_active | input | 1 | Debugger attached |
| sec_core_en | input | 1 | Secure core enabled |
| sboot_lock | input | 1 | Blocks secure-install boot at the locked level |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Gate can accept a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_region | input | 3 | Target region code |
| req_core | input | 1 | Index of the issuing core |
| rsp_valid | output | 1 | Response valid |
| rsp_error | output | 1 | Bus error response |
| fault | output | 2 | Hard-fault pulse, one bit per core |
| dbg_en | output | 1 | Debug port enable |
| boot_sel | output | 2 | Effective boot mode |
| boot_fallback | output | 1 | Sticky: a boot request was overridden |

## Verification
Directed steps come first. They walk each level through each boot mode and each region so that the individual terms of the decision show up one at a time. Separating a debug-only refusal from a boot-mode refusal shows whether R3 uses the requested boot mode or the effective one. Comparing option-byte reads with writes from each core, with the secure-core flag on and off, separates R9 from the region rule of R3. A long run with a fixed seed then randomises every input, so that the combinations no directed step picks are also covered. Gaps in req_valid in that run show whether responses appear only after accepted requests.

// File: rtl/rdp_gate_pkg.sv
package rdp_gate_pkg;

   typedef enum logic [1:0] {
      BOOT_FLASH  = 2'd0,
      BOOT_RAM    = 2'd1,
      BOOT_LOADER = 2'd2,
      BOOT_SINST  = 2'd3
   } boot_e;

   typedef enum logic [2:0] {
      RGN_FLASH  = 3'd0,
      RGN_BACKUP = 3'd1,
      RGN_RSRAM  = 3'd2,
      RGN_OPTION = 3'd3
   } region_e;

   localparam int unsigned LEVEL_W  = 2;
   localparam int unsigned BOOT_W   = 2;
   localparam int unsigned REGION_W = 3;

   function automatic logic level_is_locked(input logic [LEVEL_W-1:0] lvl);
      return lvl[LEVEL_W-1];
   endfunction

endpackage

// File: rtl/rdp_boot_resolve.sv
module rdp_boot_resolve
   import rdp_gate_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEVEL_W-1:0] prot_level,
   input  logic [BOOT_W-1:0] boot_req,
   input  logic              sboot_lock,
   output logic [BOOT_W-1:0] boot_sel,
   output logic              boot_fallback,
   output logic              dbg_en
);

   logic locked;
   logic forbid;
   logic fallback_q;
   logic dbg_q;

   assign locked = level_is_locked(prot_level);

   always_comb begin
      forbid = 1'b0;
      if (locked) begin
         unique case (boot_e'(boot_req))
            BOOT_RAM, BOOT_LOADER: forbid = 1'b1;
            BOOT_SINST:            forbid = sboot_lock;
            default:               forbid = 1'b0;
         endcase
      end
   end

   assign boot_sel = forbid ? BOOT_FLASH : boot_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fallback_q <= 1'b0;
         dbg_q      <= 1'b0;
      end else begin
         fallback_q <= fallback_q | forbid;
         dbg_q      <= ~locked;
      end
   end

   assign boot_fallback = fallback_q;
   assign dbg_en        = dbg_q;

endmodule

// File: rtl/rdp_access_policy.sv
module rdp_access_policy
   import rdp_gate_pkg::*;
#(
   parameter int unsigned NUM_CORES = 2,
   parameter int unsigned SEC_CORE  = 1,
   localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic [LEVEL_W-1:0]  prot_level,
   input  logic [BOOT_W-1:0]   boot_sel,
   input  logic                dbg_active,
   input  logic                sec_core_en,
   input  logic [REGION_W-1:0] region,
   input  logic                write,
   input  logic [CORE_W-1:0]   core,
   output logic                deny
);

   logic guarded;
   logic locked;
   logic restricted;
   logic protected_rgn;
   logic secure_master;
   logic deny_mode;
   logic deny_option;

   assign guarded       = (prot_level != '0);
   assign locked        = level_is_locked(prot_level);
   assign restricted    = dbg_active | (boot_e'(boot_sel) != BOOT_FLASH);
   assign protected_rgn = (region == RGN_FLASH) | (region == RGN_BACKUP) |
                          (region == RGN_RSRAM);
   assign secure_master = sec_core_en & (core == CORE_W'(SEC_CORE));

   assign deny_mode   = guarded & restricted & protected_rgn;
   assign deny_option = locked & write & (region == RGN_OPTION) & ~secure_master;
   assign deny        = deny_mode | deny_option;

endmodule

// File: rtl/rdp_rsp_stage.sv
module rdp_rsp_stage #(
   parameter int unsigned NUM_CORES = 2,
   localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 accept,
   input  logic                 deny,
   input  logic [CORE_W-1:0]    core,
   output logic                 ready,
   output logic                 rsp_valid,
   output logic                 rsp_error,
   output logic [NUM_CORES-1:0] fault
);

   logic ready_q;
   logic valid_q;
   logic err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         valid_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         ready_q <= 1'b1;
         valid_q <= accept;
         err_q   <= accept & deny;
      end
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_fault
      logic hit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hit_q <= 1'b0;
         else        hit_q <= accept & deny & (core == CORE_W'(c));
      end
      assign fault[c] = hit_q;
   end

   assign ready     = ready_q;
   assign rsp_valid = valid_q;
   assign rsp_error = err_q;

endmodule

// File: rtl/rdp_access_gate.sv
module rdp_access_gate
   import rdp_gate_pkg::*;
#(
   parameter int unsigned NUM_CORES = 2,
   parameter int unsigned SEC_CORE  = 1,
   localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           prot_level,
   input  logic [1:0]           boot_req,
   input  logic                 dbg_active,
   input  logic                 sec_core_en,
   input  logic                 sboot_lock,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic [2:0]           req_region,
   input  logic [CORE_W-1:0]    req_core,
   output logic                 rsp_valid,
   output logic                 rsp_error,
   output logic [NUM_CORES-1:0] fault,
   output logic                 dbg_en,
   output logic [1:0]           boot_sel,
   output logic                 boot_fallback
);

   initial begin
      if (NUM_CORES < 2)
         $error("rdp_access_gate: NUM_CORES must be at least 2");
      if (SEC_CORE >= NUM_CORES)
         $error("rdp_access_gate: SEC_CORE out of range");
   end

   logic deny;
   logic accept;

   assign accept = req_valid & req_ready;

   rdp_boot_resolve u_boot (
      .clk           (clk),
      .rst_n         (rst_n),
      .prot_level    (prot_level),
      .boot_req      (boot_req),
      .sboot_lock    (sboot_lock),
      .boot_sel      (boot_sel),
      .boot_fallback (boot_fallback),
      .dbg_en        (dbg_en)
   );

   rdp_access_policy #(
      .NUM_CORES (NUM_CORES),
      .SEC_CORE  (SEC_CORE)
   ) u_policy (
      .prot_level  (prot_level),
      .boot_sel    (boot_sel),
      .dbg_active  (dbg_active),
      .sec_core_en (sec_core_en),
      .region      (req_region),
      .write       (req_write),
      .core        (req_core),
      .deny        (deny)
   );

   rdp_rsp_stage #(
      .NUM_CORES (NUM_CORES)
   ) u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .deny      (deny),
      .core      (req_core),
      .ready     (req_ready),
      .rsp_valid (rsp_valid),
      .rsp_error (rsp_error),
      .fault     (fault)
   );

endmodule

// File: rtl/rdp_access_gate_chk.sv
module rdp_access_gate_chk #(
   parameter int unsigned NUM_CORES = 2,
   localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [1:0]           prot_level,
   input logic [1:0]           boot_req,
   input logic                 req_valid,
   input logic                 req_ready,
   input logic                 rsp_valid,
   input logic                 rsp_error,
   input logic [NUM_CORES-1:0] fault,
   input logic                 dbg_en,
   input logic [1:0]           boot_sel,
   input logic                 boot_fallback
);

   a_r4_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);

   a_r4_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready) |=> !rsp_valid);

   a_r5_fault_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fault));

   a_r5_fault_means_error: assert property (@(posedge clk) disable iff (!rst_n)
      (fault != '0) |-> (rsp_valid && rsp_error));

   a_r2_open_level_grants: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && prot_level == 2'd0) |=> !rsp_error);

   a_r6_debug_off_locked: assert property (@(posedge clk) disable iff (!rst_n)
      prot_level[1] |=> !dbg_en);

   a_r7_ram_loader_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_level[1] && (boot_req == 2'd1 || boot_req == 2'd2)) |-> (boot_sel == 2'd0));

   a_r8_fallback_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      boot_fallback |=> boot_fallback);

endmodule

bind rdp_access_gate rdp_access_gate_chk #(.NUM_CORES(NUM_CORES)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .prot_level    (prot_level),
   .boot_req      (boot_req),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .rsp_valid     (rsp_valid),
   .rsp_error     (rsp_error),
   .fault         (fault),
   .dbg_en        (dbg_en),
   .boot_sel      (boot_sel),
   .boot_fallback (boot_fallback)
);

// File: tb/test_rdp_access_gate.sv
module test_rdp_access_gate;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] prot_level = 2'd0;
   logic [1:0] boot_req = 2'd0;
   logic       dbg_active = 1'b0;
   logic       sec_core_en = 1'b0;
   logic       sboot_lock = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic       req_write = 1'b0;
   logic [2:0] req_region = 3'd0;
   logic       req_core = 1'b0;
   logic       rsp_valid;
   logic       rsp_error;
   logic [1:0] fault;
   logic       dbg_en;
   logic [1:0] boot_sel;
   logic       boot_fallback;

   int checks = 0;
   int errors = 0;
   logic sticky_exp = 1'b0;

   always #4 clk = ~clk;

   rdp_access_gate i_rdp_access_gate (
      .clk(clk), .rst_n(rst_n), .prot_level(prot_level), .boot_req(boot_req),
      .dbg_active(dbg_active), .sec_core_en(sec_core_en), .sboot_lock(sboot_lock),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_region(req_region), .req_core(req_core), .rsp_valid(rsp_valid),
      .rsp_error(rsp_error), .fault(fault), .dbg_en(dbg_en), .boot_sel(boot_sel),
      .boot_fallback(boot_fallback)
   );

   function automatic logic [1:0] exp_boot(input logic [1:0] lvl, input logic [1:0] b,
                                           input logic lock);
      if (lvl >= 2 && (b == 2'd1 || b == 2'd2)) return 2'd0;
      if (lvl >= 2 && b == 2'd3 && lock) return 2'd0;
      return b;
   endfunction

   function automatic logic exp_deny(input logic [1:0] lvl, input logic [1:0] b,
                                     input logic dbg, input logic lock,
                                     input logic [2:0] rgn, input logic wr,
                                     input logic core, input logic sen);
      logic [1:0] eb;
      eb = exp_boot(lvl, b, lock);
      if (lvl == 2'd0) return 1'b0;
      if ((dbg || eb != 2'd0) && rgn <= 3'd2) return 1'b1;
      if (lvl >= 2 && rgn == 3'd3 && wr && !(core == 1'b1 && sen)) return 1'b1;
      return 1'b0;
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // drive at negedge, verify at next negedge
   task automatic step(input logic [1:0] lvl, input logic [1:0] b, input logic dbg,
                       input logic lock, input logic sen, input logic vld,
                       input logic [2:0] rgn, input logic wr, input logic core,
                       input string tag);
      logic d;
      logic [1:0] eb;
      @(negedge clk);
      prot_level = lvl; boot_req = b; dbg_active = dbg; sboot_lock = lock;
      sec_core_en = sen; req_valid = vld; req_region = rgn; req_write = wr;
      req_core = core;
      #1;
      eb = exp_boot(lvl, b, lock);
      check({tag, " R7 boot_sel"}, {6'd0, boot_sel}, {6'd0, eb});
      d = exp_deny(lvl, b, dbg, lock, rgn, wr, core, sen);
      if (eb != b) sticky_exp = 1'b1;
      @(negedge clk);
      check({tag, " R4 rsp_valid"}, {7'd0, rsp_valid}, {7'd0, vld});
      check({tag, " R3 rsp_error"}, {7'd0, rsp_error}, {7'd0, vld & d});
      check({tag, " R5 fault"}, {6'd0, fault},
            {6'd0, (vld & d) ? (core ? 2'b10 : 2'b01) : 2'b00});
      check({tag, " R6 dbg_en"}, {7'd0, dbg_en}, {7'd0, lvl < 2});
      check({tag, " R8 boot_fallback"}, {7'd0, boot_fallback}, {7'd0, sticky_exp});
      req_valid = 1'b0;
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check("R1 ready",    {7'd0, req_ready},     8'd0);
      check("R1 rsp",      {6'd0, rsp_valid, rsp_error}, 8'd0);
      check("R1 fault",    {6'd0, fault},         8'd0);
      check("R1 dbg_en",   {7'd0, dbg_en},        8'd0);
      check("R1 fallback", {7'd0, boot_fallback}, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ready after reset", {7'd0, req_ready}, 8'd1);

      // R2 open level, restricted modes
      step(2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0, "R2 open ram dbg");
      step(2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 3'd3, 1'b1, 1'b0, "R2 open opt wr");
      // R3 guarded level
      step(2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b1, "R3 dbg backup");
      step(2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 1'b1, 1'b0, "R3 loader sram");
      step(2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 1'b1, 1'b0, "R3 ram option");
      step(2'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 3'd5, 1'b0, 1'b1, "R3 unprot");
      step(2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0, "R3 flash clean");
      step(2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R4 idle");
      // R10 / R9 locked level, flash boot, no fallback yet
      step(2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0, "R10 locked flash");
      step(2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 1'b1, "R10 level3 sram");
      step(2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd3, 1'b1, 1'b0, "R9 opt wr core0");
      step(2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 1'b1, 1'b1, "R9 opt wr sec off");
      step(2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd3, 1'b1, 1'b1, "R9 opt wr secure");
      step(2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 1'b0, 1'b0, "R9 opt read");
      step(2'd2, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, "R7 sinst allowed");
      step(2'd2, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, "R8 sinst locked");
      step(2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1, "R8 sticky holds");

      for (int i = 0; i < 600; i++) begin
         step(2'($urandom_range(3)), 2'($urandom_range(3)), 1'($urandom_range(1)),
              1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)),
              3'($urandom_range(7)), 1'($urandom_range(1)), 1'($urandom_range(1)),
              "rand");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule